// File: doc/BRIEF.md
# Multi-Mode Horizontal/Vertical Sync Generator

This block produces the horizontal and vertical sync outputs for a display back end. It runs entirely in the back-end clock domain. A pixel counter walks across each line and a line counter walks down each frame. Software-set lengths define the size of both counters. Software-set widths define how long each sync pulse lasts: the horizontal width is counted in clocks and the vertical width is counted in lines.

A two-bit mode input chooses how the timing relates to an incoming reference. The reference arrives as single-clock horizontal and vertical pulses from a sync separator.

- In the mixed mode, the horizontal timing free-runs from the pixel counter. The vertical output copies the reference vertical pulse after one register stage.
- In the locked mode, a reference horizontal pulse restarts the pixel counter, and a reference vertical pulse restarts the line counter. Both outputs therefore follow the input.
- In the free-running mode, both outputs come from the counters alone. Reference pulses are ignored, so the timing stays stable when no input signal is present.

A new mode value is only taken when a line begins, so a switch never cuts a sync pulse short.

Top module: `hv_sync_gen`

## Requirements
- R1: While reset is low, the pixel count and line count read zero, and the mode in force is free-running.
- R2: Apart from a locked-mode restart, the pixel count steps by one per clock. On the clock after it reads line_len-1 or more, it returns to zero.
- R3: Each time the pixel count returns to zero, the line count steps by one. When it reads frame_len-1 or more, it returns to zero instead.
- R4: hout is high exactly while the pixel count is below hs_width, in every mode.
- R5: In the locked mode and in the free-running modes, vout is high exactly while the line count is below vs_width.
- R6: In the mixed mode (mode_sel 2'b00), vout equals ref_v delayed by one clock, and ref_h has no effect on the counters.
- R7: In the locked mode (mode_sel 2'b01), a high ref_h makes the pixel count zero on the next clock. The line count then advances as for a normal line end.
- R8: In the locked mode, a high ref_v makes the line count zero on the next clock. This takes precedence over a line advance in the same clock.
- R9: In the free-running modes (mode_sel 2'b10, and 2'b11 treated the same way), ref_h and ref_v have no effect on any output.
- R10: A change of mode_sel is captured only on a clock in which the pixel count returns to zero. It governs the outputs from the first pixel of the new line onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Back-end clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Requested mode: 00 mixed, 01 locked, 10/11 free-running |
| ref_h | input | 1 | Reference horizontal pulse from the sync separator |
| ref_v | input | 1 | Reference vertical pulse from the sync separator |
| line_len | input | CNT_W | Clocks per line (at least 2) |
| frame_len | input | LINE_W | Lines per frame (at least 2) |
| hs_width | input | CNT_W | Horizontal sync width in clocks |
| vs_width | input | LINE_W | Vertical sync width in lines |
| hout | output | 1 | Horizontal sync output |
| vout | output | 1 | Vertical sync output |
| pix_cnt | output | CNT_W | Current pixel count |
| line_cnt | output | LINE_W | Current line count |

## Verification
The bench builds the block with CNT_W of 8 and LINE_W of 6. It programs lines of 10 and then 7 clocks, and frames of 5 and then 3 lines. These short lengths let hundreds of line wraps and dozens of frame wraps happen within a few thousand clocks.

The reference pulse periods are chosen both shorter and longer than a line. This exercises restarts in the middle of a line as well as natural wraps. Mode requests are changed in the middle of lines, so the deferral to the next line start is exercised.

A vertical width equal to the frame length and a horizontal width of zero are also applied. These cover the cases where a sync output is always high or always low.

// File: rtl/hvs_pkg.sv
// Shared definitions for the sync generator: mode encoding.
package hvs_pkg;
    typedef enum logic [1:0] {
        MODE_MIX      = 2'b00,  // H from counter, V from reference
        MODE_LOCK     = 2'b01,  // H and V restarted by reference
        MODE_FREE     = 2'b10,  // both from counters
        MODE_FREE_ALT = 2'b11   // same as MODE_FREE
    } sync_mode_t;
endpackage

// File: rtl/hvs_mode_ctl.sv
// Holds the mode in force. A requested mode is captured only on a clock in
// which a new line begins, so pulse timing never switches mid-line.
// Assumes line_start is high for exactly the clocks where the pixel
// counter loads zero.
module hvs_mode_ctl
    import hvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       line_start,
    output sync_mode_t act_mode
);
    // Mode register: reset to free-running, reload at line start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_mode <= MODE_FREE;
        else if (line_start)
            act_mode <= sync_mode_t'(mode_sel);
    end

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(act_mode));
endmodule

// File: rtl/hvs_pixel_ctr.sv
// Pixel counter across one line. Wraps after line_len-1 (or any larger
// value after a length change) and restarts on clr. Flags the clock on
// which the counter loads zero. Assumes line_len >= 2.
module hvs_pixel_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] line_len,
    output logic [CNT_W-1:0] pix_q,
    output logic             line_start
);
    logic at_end;

    // End-of-line detect and line-start flag.
    always_comb begin
        at_end     = (pix_q >= line_len - 1'b1);
        line_start = at_end || clr;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_q <= '0;
        else if (line_start)
            pix_q <= '0;
        else
            pix_q <= pix_q + 1'b1;
    end

    assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (pix_q < line_len - 1'b1)) |=> (pix_q == $past(pix_q) + 1'b1));
    assert_pix_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pix_q == '0));
endmodule

// File: rtl/hvs_line_ctr.sv
// Line counter down one frame. Advances on step, wraps after frame_len-1,
// and clears on clr with priority over step. Assumes frame_len >= 2.
module hvs_line_ctr #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [LINE_W-1:0] frame_len,
    output logic [LINE_W-1:0] line_q
);
    logic at_last;

    // End-of-frame detect.
    always_comb at_last = (line_q >= frame_len - 1'b1);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else if (clr)
            line_q <= '0;
        else if (step)
            line_q <= at_last ? '0 : line_q + 1'b1;
    end

    assert_line_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (line_q == '0));
    assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && (line_q < frame_len - 1'b1)) |=> (line_q == $past(line_q) + 1'b1));
    assert_line_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(line_q));
endmodule

// File: rtl/hv_sync_gen.sv
// Top of the sync generator. Combines the mode register, pixel counter and
// line counter, and forms hout/vout from the counts or from the reference
// vertical pulse according to the mode in force. Reference pulses are
// assumed to be synchronous to clk.
module hv_sync_gen
    import hvs_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              ref_h,
    input  logic              ref_v,
    input  logic [CNT_W-1:0]  line_len,
    input  logic [LINE_W-1:0] frame_len,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic [LINE_W-1:0] vs_width,
    output logic              hout,
    output logic              vout,
    output logic [CNT_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    sync_mode_t act_mode;
    logic       locked;
    logic       h_clr;
    logic       v_clr;
    logic       line_start;
    logic       ref_v_q;

    // Reference restarts are honoured only in the locked mode.
    always_comb begin
        locked = (act_mode == MODE_LOCK);
        h_clr  = locked && ref_h;
        v_clr  = locked && ref_v;
    end

    hvs_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .line_start (line_start),
        .act_mode   (act_mode)
    );

    hvs_pixel_ctr #(.CNT_W(CNT_W)) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (h_clr),
        .line_len   (line_len),
        .pix_q      (pix_cnt),
        .line_start (line_start)
    );

    hvs_line_ctr #(.LINE_W(LINE_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (v_clr),
        .step      (line_start),
        .frame_len (frame_len),
        .line_q    (line_cnt)
    );

    // One register stage on the reference vertical pulse for the mixed mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_v_q <= 1'b0;
        else
            ref_v_q <= ref_v;
    end

    // Output pulse forming.
    always_comb begin
        hout = (pix_cnt < hs_width);
        if (act_mode == MODE_MIX)
            vout = ref_v_q;
        else
            vout = (line_cnt < vs_width);
    end

    assert_mix_vout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start == 1'b0 && act_mode == MODE_MIX) |=> (vout == $past(ref_v)));
endmodule

// File: tb/hv_sync_gen_tb.sv
// Bench: a behavioural model advanced on every rising edge and compared
// with the design on every falling edge.
module hv_sync_gen_tb_top;
    localparam int CW = 8;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'b10;
    logic          ref_h = 1'b0;
    logic          ref_v = 1'b0;
    logic [CW-1:0] line_len = 8'd10;
    logic [LW-1:0] frame_len = 6'd5;
    logic [CW-1:0] hs_width = 8'd3;
    logic [LW-1:0] vs_width = 6'd2;
    logic          hout, vout;
    logic [CW-1:0] pix_cnt;
    logic [LW-1:0] line_cnt;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int hp = 7, vp = 23;
    bit pulses_on = 1'b0;
    bit done = 1'b0;

    // Model state.
    int m_pix = 0, m_line = 0, m_md = 2, m_vq = 0;
    bit m_md_changed = 1'b0;

    hv_sync_gen #(.CNT_W(CW), .LINE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_h(ref_h), .ref_v(ref_v),
        .line_len(line_len), .frame_len(frame_len), .hs_width(hs_width), .vs_width(vs_width),
        .hout(hout), .vout(vout), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
    );

    always #10 clk = ~clk;

    // Reference pulse generator, driven just after the rising edge.
    always @(posedge clk) begin
        #2;
        cyc = cyc + 1;
        ref_h = pulses_on && (cyc % hp == 0);
        ref_v = pulses_on && (cyc % vp == 0);
    end

    // Behavioural model step.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pix = 0; m_line = 0; m_md = 2; m_vq = 0; m_md_changed = 1'b0;
        end else begin
            bit lk, ls;
            int npix, nline, nmd;
            lk = (m_md == 1);
            ls = (lk && ref_h) || (m_pix >= int'(line_len) - 1);
            npix = ls ? 0 : m_pix + 1;
            if (lk && ref_v) nline = 0;
            else if (ls) nline = (m_line >= int'(frame_len) - 1) ? 0 : m_line + 1;
            else nline = m_line;
            nmd = ls ? int'(mode_sel) : m_md;
            m_md_changed = (nmd != m_md);
            m_vq = ref_v;
            m_pix = npix; m_line = nline; m_md = nmd;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Compare on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string ctag, ptag, ltag, vtag;
            int ev;
            ctag = m_md_changed ? "R10" : "";
            ptag = (m_md == 1) ? "R7" : (m_md >= 2 ? "R2/R9" : "R2/R6");
            ltag = (m_md == 1) ? "R3/R8" : (m_md >= 2 ? "R3/R9" : "R3");
            vtag = (m_md == 0) ? "R6" : (m_md >= 2 ? "R5/R9" : "R5");
            ev = (m_md == 0) ? m_vq : (m_line < int'(vs_width));
            chk({ptag, " ", ctag, " pix"}, int'(pix_cnt), m_pix);
            chk({ltag, " ", ctag, " line"}, int'(line_cnt), m_line);
            chk({"R4 ", ctag, " hout"}, int'(hout), int'(m_pix < int'(hs_width)));
            chk({vtag, " ", ctag, " vout"}, int'(vout), ev);
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Watchdog.
    initial begin
        #3_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pix", int'(pix_cnt), 0);
        chk("R1 line", int'(line_cnt), 0);
        chk("R1 hout", int'(hout), 1);
        chk("R1 vout free-run", int'(vout), 1);
        @(posedge clk); #2;
        rst_n = 1'b1;
        pulses_on = 1'b1;
        wait_clks(300);                 // R9: free-running, pulses ignored
        mode_sel = 2'b00; wait_clks(300);   // R6 mixed
        mode_sel = 2'b01; hp = 13; vp = 37; wait_clks(300);   // R7/R8 long H period
        hp = 6; wait_clks(300);         // R7 short H period
        hp = 5; vp = 5; wait_clks(200);     // R8 H and V together
        mode_sel = 2'b11; hp = 7; vp = 11; wait_clks(200);   // R9 alt code
        line_len = 8'd7; frame_len = 6'd3; hs_width = 8'd0; vs_width = 6'd3;
        mode_sel = 2'b01; hp = 9; vp = 29; wait_clks(300);
        mode_sel = 2'b00; wait_clks(200);
        mode_sel = 2'b10; wait_clks(200);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule